// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management side of an Ethernet PHY management link. It runs a single clause-22 style register access over a management clock and a shared bidirectional data line. The host writes one 32-bit frame word. That word holds the start pattern, the opcode, the PHY and register addresses, the turnaround pair and the write data. The same write launches the transfer. A preamble of 32 ones goes out first, and then the frame word, most significant bit first.

For a read, the master releases the data line for the PHY's turnaround slot. It captures the 16 returned bits and places them in the low half of the frame word, where the host reads them. At the end of every frame the block raises a sticky completion event. The host clears it by writing one. A separate enable routes the event to an interrupt output, and the event stays readable while that enable is off. A speed register sets the management clock: it stays high for that many system clocks and low for that many. Software programs it as (system clock in MHz / 5) + 1, which keeps the clock at or below 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset the management clock is low, the data line is released (mdio_oe_o = 0), the event flag is 0, the interrupt is 0 and the frame word reads 0.
- R2: A write to register address 0 loads the frame word and starts a frame. On the data line the block sends 32 ones, then frame bits 31 down to 0, one bit per management clock period.
- R3: With speed value S (register address 1, bits [5:0]), the management clock is high for S system clocks and low for S system clocks, and it stays low while no frame runs. The data line changes only while the clock is falling, so it is stable across every rising edge.
- R4: When frame bits [29:28] are 10 (read), the master drives the line for serial bits 0 to 46 and releases it from serial bit 47 (the second turnaround bit) to the end. When they are 01 (write), it drives all 64 bits.
- R5: On a read, the line is sampled at the rising clock edges of serial bits 48 to 63, first bit into bit 15. At completion these 16 bits replace frame bits [15:0], and bits [31:16] keep the written value.
- R6: Completion sets the event flag. The flag stays set until the host writes a 1 to bit 0 of register address 2. Writing 0 there has no effect.
- R7: irq_o follows the event flag while bit 0 of register address 3 is 1. It stays low while that bit is 0, and event_o still shows the flag.
- R8: While the speed value is 0, a frame write is ignored. The frame word is not changed, no clock edge is produced and no event is set.
- R9: A frame write that arrives while a frame is running is ignored. The frame word and the bits on the line keep the first frame's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | 0 frame, 1 speed, 2 event clear, 3 interrupt enable |
| reg_wdata_i | input | 32 | Register write data |
| frame_o | output | 32 | Frame word readback, holds read data after a read |
| event_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Completion interrupt |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Assertions check several properties on every cycle: the clock stays low when idle, the data output holds across each rising edge, the event flag rises only at the end of a running frame, the frame word stays stable while a frame runs, and a zero speed value never starts a frame. Only the bench scenarios can show the serial content of whole frames, the exact line release point on reads, and the read data placed in the frame word. The same holds for the measured clock high and low times, and for write-one-to-clear and interrupt enable behaviour seen at the ports.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned FRAME_W    = 32;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned TOTAL_BITS = PRE_BITS + FRAME_W;
  localparam int unsigned BIT_W      = $clog2(TOTAL_BITS);
  localparam logic [BIT_W-1:0] IDX_TA2  = BIT_W'(TOTAL_BITS - DATA_W - 1);
  localparam logic [BIT_W-1:0] IDX_DATA = BIT_W'(TOTAL_BITS - DATA_W);
  localparam logic [BIT_W-1:0] IDX_LAST = BIT_W'(TOTAL_BITS - 1);
  localparam int unsigned OP_HI = 29;
  localparam int unsigned OP_LO = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    REG_FRAME = 2'd0,
    REG_SPEED = 2'd1,
    REG_EVCLR = 2'd2,
    REG_IRQEN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap   = en_i && (cnt_q == half_i - 1'b1);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: high phase always ends in a falling toggle, never two rises in a row
  a_r3_alt_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> mdc_q);
endmodule

// File: rtl/mdio_frame_shift.sv
`timescale 1ns/1ps
module mdio_frame_shift
  import mdio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               rd_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DATA_W-1:0]  rx_o
);
  logic [TOTAL_BITS-1:0] sh_q;
  logic [BIT_W-1:0]      bit_q;
  logic [DATA_W-1:0]     rx_q;
  logic                  busy_q, rd_q;

  assign done_o    = busy_q && fall_i && (bit_q == IDX_LAST);
  assign mdio_o    = sh_q[TOTAL_BITS-1];
  assign mdio_oe_o = busy_q && !(rd_q && (bit_q >= IDX_TA2));
  assign busy_o    = busy_q;
  assign rd_o      = rd_q;
  assign rx_o      = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bit_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (start_i && !busy_q) begin
      sh_q   <= {{PRE_BITS{1'b1}}, frame_i};
      bit_q  <= '0;
      rx_q   <= '0;
      busy_q <= 1'b1;
      rd_q   <= (frame_i[OP_HI:OP_LO] == OP_READ);
    end else if (busy_q) begin
      if (rise_i && rd_q && (bit_q >= IDX_DATA))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (bit_q == IDX_LAST) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[TOTAL_BITS-2:0], 1'b0};
        end
      end
    end
  end

  // R2: a frame ends only after the counter walked through every serial bit
  a_r2_done_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(bit_q) == IDX_LAST);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned SPD_W = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] frame_o,
  output logic        event_o,
  output logic        irq_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [FRAME_W-1:0] frame_q;
  logic [SPD_W-1:0]   spd_q, spd_lat_q;
  logic               evt_q, irq_en_q;
  logic               busy, done, rd, rise, fall, start;
  logic [DATA_W-1:0]  rx;
  reg_sel_e           sel;

  assign sel   = reg_sel_e'(reg_addr_i);
  assign start = reg_we_i && (sel == REG_FRAME) && !busy && (spd_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= '0;
      spd_q     <= '0;
      spd_lat_q <= '0;
      evt_q     <= 1'b0;
      irq_en_q  <= 1'b0;
    end else begin
      if (start) begin
        frame_q   <= reg_wdata_i;
        spd_lat_q <= spd_q;
      end else if (done && rd) begin
        frame_q[DATA_W-1:0] <= rx;
      end
      if (reg_we_i && sel == REG_SPEED) spd_q <= reg_wdata_i[SPD_W-1:0];
      if (reg_we_i && sel == REG_IRQEN) irq_en_q <= reg_wdata_i[0];
      if (done)                                          evt_q <= 1'b1;
      else if (reg_we_i && sel == REG_EVCLR && reg_wdata_i[0]) evt_q <= 1'b0;
    end
  end

  mdio_clk_div #(.CNT_W(SPD_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .half_i (spd_lat_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .frame_i   (reg_wdata_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rd_o      (rd),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rx_o      (rx)
  );

  assign frame_o = frame_q;
  assign event_o = evt_q;
  assign irq_o   = evt_q && irq_en_q;

  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  a_r3_hold_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o));
  a_r6_event_from_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q) |-> $past(busy));
  a_r9_frame_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(frame_q));
  a_r8_zero_speed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && spd_q == '0) |=> !busy);
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] frame_o;
  logic        event_o, irq_o, mdc_o, mdio_o, mdio_oe_o, mdio_i;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int          bidx = 0;
  logic [63:0] cap_bit, cap_oe;
  logic [15:0] rsp = '0;
  realtime     rise_t0, rise_t1, fall_t0;

  always #2.5 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .frame_o(frame_o), .event_o(event_o), .irq_o(irq_o),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // PHY model: answers read data on serial bits 48..63
  assign mdio_i = (bidx >= 48 && bidx < 64) ? rsp[63-bidx] : 1'b1;

  always @(posedge mdc_o) begin
    if (bidx < 64) begin
      cap_bit[bidx] = mdio_o;
      cap_oe[bidx]  = mdio_oe_o;
    end
    if (bidx == 0) rise_t0 = $realtime;
    if (bidx == 1) rise_t1 = $realtime;
    bidx++;
  end
  always @(negedge mdc_o) if (bidx == 1) fall_t0 = $realtime;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic exp_bit(input logic [31:0] f, input int k);
    return (k < 32) ? 1'b1 : f[63-k];
  endfunction
  function automatic logic exp_oe(input logic [31:0] f, input int k);
    return (f[29:28] == 2'b10) ? (k < 47) : 1'b1;
  endfunction
  function automatic logic [31:0] exp_frame(input logic [31:0] f, input logic [15:0] r);
    return (f[29:28] == 2'b10) ? {f[31:16], r} : f;
  endfunction

  task automatic wait_event(input string req);
    int n = 0;
    while (!event_o && n < 20000) begin @(negedge clk); n++; end
    chk(event_o, req, {63'd0, event_o}, 64'd1);
  endtask

  task automatic run_frame(input logic [31:0] f, input int s, input logic [15:0] r, input bit intf);
    logic [63:0] eb, eo, db, mask;
    wr(2'd1, 32'(s));
    wr(2'd2, 32'd1);
    bidx = 0; rsp = r;
    wr(2'd0, f);
    if (intf) begin
      repeat (10) @(negedge clk);
      wr(2'd0, ~f);
      chk(frame_o == f, "R9 frame word during busy write", {32'd0, frame_o}, {32'd0, f});
    end
    wait_event("R6 completion event");
    repeat (2) @(negedge clk);
    for (int k = 0; k < 64; k++) begin
      eb[k] = exp_bit(f, k);
      eo[k] = exp_oe(f, k);
    end
    mask = eo;
    db = cap_bit & mask;
    chk(bidx == 64, "R2 rising edge count", 64'(bidx), 64'd64);
    chk(db == (eb & mask), "R2 serial bits", db, eb & mask);
    chk(cap_oe == eo, "R4 output enable pattern", cap_oe, eo);
    chk(frame_o == exp_frame(f, r), "R5 frame readback", {32'd0, frame_o}, {32'd0, exp_frame(f, r)});
    chk($rtoi(rise_t1 - rise_t0) == 10 * s, "R3 clock period", 64'($rtoi(rise_t1 - rise_t0)), 64'(10 * s));
    chk($rtoi(fall_t0 - rise_t0) == 5 * s, "R3 clock high time", 64'($rtoi(fall_t0 - rise_t0)), 64'(5 * s));
    chk(!mdc_o && !mdio_oe_o, "R3 idle after frame", {62'd0, mdc_o, mdio_oe_o}, 64'd0);
  endtask

  function automatic logic [31:0] rnd_frame();
    logic [1:0] op = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
    logic [27:0] rest = 28'($urandom());
    return {2'b01, op, rest[27:18], 2'b10, rest[15:0]};
  endfunction

  initial begin
    logic [31:0] f;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mdc_o && !mdio_oe_o && !event_o && !irq_o && frame_o == 0, "R1 reset state",
        {27'd0, mdc_o, mdio_oe_o, event_o, irq_o, frame_o}, 64'd0);

    // R8: zero speed ignores the frame write
    bidx = 0;
    wr(2'd0, 32'h5002_1234);
    repeat (40) @(negedge clk);
    chk(bidx == 0 && frame_o == 0 && !event_o, "R8 zero speed ignored",
        {event_o, 31'(bidx), frame_o}, 64'd0);

    // directed write and read
    run_frame(32'h5086_A5C3, 1, 16'h0000, 1'b0);
    run_frame(32'h6086_0000, 2, 16'hBEEF, 1'b0);
    run_frame(32'h6FFE_FFFF, 1, 16'h0001, 1'b0);

    // R6: sticky, W1C only with bit 0 set
    wr(2'd2, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    chk(event_o, "R6 write of 0 keeps flag", {63'd0, event_o}, 64'd1);
    // R7: enable routing
    wr(2'd3, 32'd0);
    @(negedge clk);
    chk(!irq_o && event_o, "R7 disabled interrupt", {62'd0, irq_o, event_o}, 64'd1);
    wr(2'd3, 32'd1);
    @(negedge clk);
    chk(irq_o, "R7 enabled interrupt", {63'd0, irq_o}, 64'd1);
    wr(2'd2, 32'd1);
    @(negedge clk);
    chk(!event_o && !irq_o, "R6 write-one clear", {62'd0, event_o, irq_o}, 64'd0);

    // R9: busy write ignored
    run_frame(32'h6123_0000, 3, 16'h5A5A, 1'b1);

    // R8 again after activity: frame word keeps the previous value
    f = frame_o;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd1);
    bidx = 0;
    wr(2'd0, 32'h5555_5555);
    repeat (40) @(negedge clk);
    chk(bidx == 0 && frame_o == f && !event_o, "R8 zero speed after use",
        {event_o, 31'(bidx), frame_o}, {32'd0, f});

    for (int i = 0; i < 6; i++)
      run_frame(rnd_frame(), $urandom_range(1, 4), 16'($urandom()), 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule